// File: doc/BRIEF.md
# Periodic Four-Channel DAC Refresh Sequencer

This block keeps one 12-bit sample for each of four converter channels and rewrites all of them at a fixed sample rate. A divider built from the system clock produces the sample tick. On each tick the sequencer takes a snapshot of the host-written samples. It then hands the channels one at a time to an external frame engine. Each channel gets its own start pulse and its own frame. The sequencer waits for that frame's done before it moves on. The order is always channel 0, 1, 2, 3, so the refresh timing is the same every period whatever the host is doing.

The host can update any sample at any time. A sample is written in two parts: a high part (bits 11:4) and a low part (bits 3:0). Host writes land in shadow registers, and a burst only ever reads the snapshot taken when it started. A channel therefore never receives a sample that is half old and half new.

When the last frame of a burst completes, the sequencer does three things: it captures the readback word that frame returned, drops its busy flag and pulses a completion strobe. If a tick arrives while a burst is still running, the sequencer pulses an overrun flag and lets the running burst finish.

Top module: `dac_refresh_seq`

## Requirements
- R1: `sample_tick` is a one-cycle pulse, and consecutive pulses are exactly CLK_HZ/TICK_HZ clock cycles apart.
- R2: A tick while idle starts a burst. The burst issues exactly four frames, and their channel codes in `frm_word[19:16]` are 0, 1, 2, 3 in that order.
- R3: Each frame word is {8'h00, 4'h3 (write-and-update command), 4-bit channel code, 12-bit sample, 4'h0}. Bit 31 is the first bit on the wire.
- R4: `frm_start` is high for one cycle per frame. No new `frm_start` occurs until `frm_done` has been seen for the previous frame. The next channel starts in the cycle after that done.
- R5: A host write with `host_hi`=1 sets sample bits 11:4 from `host_data[7:0]`. A write with `host_hi`=0 sets bits 3:0 from `host_data[3:0]`, and `host_data[7:4]` has no effect.
- R6: A burst sends the samples as they stood when its tick arrived. Writes made during a burst appear in the next burst.
- R7: In the cycle `burst_done` pulses, `last_readback` holds the `frm_rdata` that came with the last frame's done. With a converter that echoes the previous command, this is the channel-2 frame word.
- R8: `refresh_busy` is high from the cycle after the starting tick until the cycle after the last done. At that point it clears, and `burst_done` pulses for one cycle.
- R9: A tick while busy produces a one-cycle `overrun` pulse in the next cycle. The running burst goes on to its fourth frame in order, and it is not restarted.
- R10: When ENFORCE_BUDGET is set, every burst ends early enough that the next tick finds the sequencer idle.
- R11: During and right after reset, `refresh_busy`, `frm_start`, `burst_done`, `overrun` and `sample_tick` are low and `last_readback` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host sample write strobe |
| host_chan | input | 2 | Channel addressed by the write |
| host_hi | input | 1 | 1 = high part (bits 11:4), 0 = low part (bits 3:0) |
| host_data | input | 8 | Write data |
| frm_start | output | 1 | Start one frame on the frame engine |
| frm_word | output | 32 | Command word for the frame |
| frm_done | input | 1 | Frame engine finished the frame |
| frm_rdata | input | 32 | Word shifted back during the frame |
| refresh_busy | output | 1 | Burst in progress |
| burst_done | output | 1 | One-cycle pulse when a burst completes |
| overrun | output | 1 | One-cycle pulse when a tick is dropped |
| sample_tick | output | 1 | Sample-rate tick |
| last_readback | output | 32 | Readback of the last frame of the latest burst |

## Verification
The assertions assume three things about the frame engine: it raises `frm_done` only once per start, it never raises it before a start, and it never raises it in the same cycle as the start. The burst-length assertion also assumes the frame latency is small enough for four frames to fit in one tick period. The stimulus meets these assumptions with a bench engine that has a fixed latency: a short one on the checked instance, and a deliberately long one on a second instance where the budget check is turned off and overruns are provoked. Host writes are placed right after a burst completes, or after busy rises, and never on the tick cycle itself.

// File: rtl/dac_refresh_pkg.sv
package dac_refresh_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

   localparam int FRAME_W   = 32;
   localparam int PAYLOAD_W = 16;
   localparam int CODE_W    = 4;
   localparam logic [3:0] CMD_WR_UPD = 4'h3;

   function automatic logic [FRAME_W-1:0] make_word(input logic [CODE_W-1:0] code,
                                                    input logic [PAYLOAD_W-1:0] payload);
      return {8'h00, CMD_WR_UPD, code, payload};
   endfunction

endpackage

// File: rtl/dac_tick_gen.sv
module dac_tick_gen #(
   parameter int unsigned DIV = 15625
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit IS_POW2 = ((DIV & (DIV - 1)) == 0);

   if (DIV < 2) begin : g_bad_div
      $error("dac_tick_gen: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   if (IS_POW2) begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= &cnt_q;
         end
      end
   end else begin : g_modulo
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
         end else begin
            tick  <= (cnt_q == LAST);
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dac_sample_bank.sv
module dac_sample_bank #(
   parameter int NUM_CH = 4,
   parameter int VAL_W  = 12,
   parameter int LO_W   = 4,
   parameter int DATA_W = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [CH_W-1:0]               chan,
   input  logic                          hi,
   input  logic [DATA_W-1:0]             data,
   input  logic                          latch,
   output logic [NUM_CH-1:0][VAL_W-1:0]  live
);
   localparam int HI_W = VAL_W - LO_W;

   if (HI_W > DATA_W || LO_W > DATA_W || LO_W < 1 || HI_W < 1) begin : g_bad_split
      $error("dac_sample_bank: sample split does not fit the host data width");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [VAL_W-1:0] shadow_q;
      logic [VAL_W-1:0] live_q;
      logic             sel;

      assign sel = we && (chan == CH_W'(c));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q <= '0;
         end else if (sel) begin
            if (hi) shadow_q[VAL_W-1:LO_W] <= data[HI_W-1:0];
            else    shadow_q[LO_W-1:0]     <= data[LO_W-1:0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)     live_q <= '0;
         else if (latch) live_q <= shadow_q;
      end

      assign live[c] = live_q;
   end

endmodule

// File: rtl/dac_burst_seq.sv
module dac_burst_seq
   import dac_refresh_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int VAL_W  = 12,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic [NUM_CH-1:0][VAL_W-1:0]  live,
   output logic                          latch,
   output logic                          frm_start,
   output logic [FRAME_W-1:0]            frm_word,
   input  logic                          frm_done,
   input  logic [FRAME_W-1:0]            frm_rdata,
   output logic                          busy,
   output logic                          burst_done,
   output logic                          overrun,
   output logic [FRAME_W-1:0]            last_rb
);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
   localparam int PAD_W = PAYLOAD_W - VAL_W;

   seq_state_e          state_q;
   logic [CH_W-1:0]     ch_q;
   logic [PAYLOAD_W-1:0] payload;

   assign busy      = (state_q != ST_IDLE);
   assign latch     = tick && (state_q == ST_IDLE);
   assign frm_start = (state_q == ST_ISSUE);

   if (PAD_W > 0) begin : g_pad
      assign payload = {live[ch_q], {PAD_W{1'b0}}};
   end else begin : g_nopad
      assign payload = live[ch_q];
   end

   assign frm_word = make_word(CODE_W'(ch_q), payload);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ch_q       <= '0;
         burst_done <= 1'b0;
         overrun    <= 1'b0;
         last_rb    <= '0;
      end else begin
         burst_done <= 1'b0;
         overrun    <= tick && (state_q != ST_IDLE);
         case (state_q)
            ST_IDLE: begin
               if (tick) begin
                  state_q <= ST_ISSUE;
                  ch_q    <= '0;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (frm_done) begin
                  if (ch_q == LAST_CH) begin
                     state_q    <= ST_IDLE;
                     burst_done <= 1'b1;
                     last_rb    <= frm_rdata;
                  end else begin
                     ch_q    <= ch_q + 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dac_refresh_seq.sv
module dac_refresh_seq
   import dac_refresh_pkg::*;
#(
   parameter int unsigned CLK_HZ         = 125_000_000,
   parameter int unsigned TICK_HZ        = 8000,
   parameter int          NUM_CH         = 4,
   parameter int          VAL_W          = 12,
   parameter int          LO_W           = 4,
   parameter int          DATA_W         = 8,
   parameter bit          ENFORCE_BUDGET = 1'b1,
   localparam int         CH_W           = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [CH_W-1:0]   host_chan,
   input  logic              host_hi,
   input  logic [DATA_W-1:0] host_data,
   output logic              frm_start,
   output logic [31:0]       frm_word,
   input  logic              frm_done,
   input  logic [31:0]       frm_rdata,
   output logic              refresh_busy,
   output logic              burst_done,
   output logic              overrun,
   output logic              sample_tick,
   output logic [31:0]       last_readback
);
   localparam int unsigned DIV = CLK_HZ / TICK_HZ;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("dac_refresh_seq: NUM_CH must be 1..16 to fit the channel code");
   end
   if (VAL_W > PAYLOAD_W || VAL_W <= LO_W) begin : g_bad_val
      $error("dac_refresh_seq: VAL_W must exceed LO_W and fit the payload");
   end
   if (TICK_HZ == 0 || DIV < 2) begin : g_bad_rate
      $error("dac_refresh_seq: clock must be at least twice the tick rate");
   end

   logic                         latch;
   logic [NUM_CH-1:0][VAL_W-1:0] live;

   dac_tick_gen #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sample_tick)
   );

   dac_sample_bank #(
      .NUM_CH (NUM_CH),
      .VAL_W  (VAL_W),
      .LO_W   (LO_W),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (host_we),
      .chan  (host_chan),
      .hi    (host_hi),
      .data  (host_data),
      .latch (latch),
      .live  (live)
   );

   dac_burst_seq #(
      .NUM_CH (NUM_CH),
      .VAL_W  (VAL_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sample_tick),
      .live       (live),
      .latch      (latch),
      .frm_start  (frm_start),
      .frm_word   (frm_word),
      .frm_done   (frm_done),
      .frm_rdata  (frm_rdata),
      .busy       (refresh_busy),
      .burst_done (burst_done),
      .overrun    (overrun),
      .last_rb    (last_readback)
   );

endmodule

// File: rtl/dac_refresh_checker.sv
module dac_refresh_checker #(
   parameter int unsigned DIV     = 15625,
   parameter int          NUM_CH  = 4,
   parameter bit          ENFORCE = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        sample_tick,
   input logic        frm_start,
   input logic [31:0] frm_word,
   input logic        frm_done,
   input logic [31:0] frm_rdata,
   input logic        refresh_busy,
   input logic        burst_done,
   input logic        overrun,
   input logic [31:0] last_readback
);
   logic [31:0] gap_q;
   logic        seen_q;
   logic [31:0] burst_cyc_q;
   logic        outstanding_q;
   logic [4:0]  idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q         <= '0;
         seen_q        <= 1'b0;
         burst_cyc_q   <= '0;
         outstanding_q <= 1'b0;
         idx_q         <= '0;
      end else begin
         gap_q         <= sample_tick ? '0 : gap_q + 1'b1;
         seen_q        <= seen_q | sample_tick;
         burst_cyc_q   <= refresh_busy ? burst_cyc_q + 1'b1 : '0;
         outstanding_q <= frm_start ? 1'b1 : (frm_done ? 1'b0 : outstanding_q);
         if (!refresh_busy) idx_q <= '0;
         else if (frm_start) idx_q <= idx_q + 1'b1;
      end
   end

   p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && seen_q) |-> (gap_q == DIV - 1));

   p_tick_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> !sample_tick);

   p_chan_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |-> ({1'b0, frm_word[19:16]} == idx_q));

   p_four_frames_r2: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> (idx_q == 5'(NUM_CH)));

   p_cmd_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |-> (frm_word[31:20] == 12'h003));

   p_start_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |-> !outstanding_q);

   p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> (last_readback == $past(frm_rdata)));

   p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> !refresh_busy);

   p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> ($past(refresh_busy) && $past(sample_tick)));

   if (ENFORCE) begin : g_budget
      p_burst_in_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
         refresh_busy |-> (burst_cyc_q < DIV - 1));
   end

endmodule

bind dac_refresh_seq dac_refresh_checker #(
   .DIV     (DIV),
   .NUM_CH  (NUM_CH),
   .ENFORCE (ENFORCE_BUDGET)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sample_tick   (sample_tick),
   .frm_start     (frm_start),
   .frm_word      (frm_word),
   .frm_done      (frm_done),
   .frm_rdata     (frm_rdata),
   .refresh_busy  (refresh_busy),
   .burst_done    (burst_done),
   .overrun       (overrun),
   .last_readback (last_readback)
);

// File: tb/dac_refresh_seq_test.sv
module frame_engine_model #(
   parameter int LAT = 8
) (
   input  logic        clk,
   input  logic        start,
   input  logic [31:0] word,
   output logic        done,
   output logic [31:0] rdata
);
   logic [31:0] log_q [0:255];
   int          n_log = 0;
   int          n_overlap = 0;
   int          n_long = 0;

   initial begin
      logic [31:0] prev;
      logic [31:0] cur;
      logic        pend;
      logic        last_start;
      int          cnt;
      prev = '0; cur = '0; pend = 1'b0; cnt = 0; last_start = 1'b0;
      done = 1'b0; rdata = '0;
      forever begin
         @(negedge clk);
         done = 1'b0;
         if (start && last_start) n_long++;
         last_start = start;
         if (pend) begin
            if (start) n_overlap++;
            if (cnt == 0) begin
               done  = 1'b1;
               rdata = prev;
               prev  = cur;
               pend  = 1'b0;
            end else begin
               cnt--;
            end
         end else if (start) begin
            cur  = word;
            pend = 1'b1;
            cnt  = LAT;
            if (n_log < 256) log_q[n_log] = word;
            n_log++;
         end
      end
   end
endmodule

module dac_refresh_seq_test;
   localparam int unsigned CLK_HZ  = 1_600_000;
   localparam int unsigned TICK_HZ = 8000;
   localparam int          DIV     = CLK_HZ / TICK_HZ;
   localparam int          NB      = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_chan = '0;
   logic        host_hi = 1'b0;
   logic [7:0]  host_data = '0;

   logic        frm_start, frm_done, refresh_busy, burst_done, overrun, sample_tick;
   logic [31:0] frm_word, frm_rdata, last_readback;

   logic        s_start, s_done, s_busy, s_bdone, s_ovr, s_tick;
   logic [31:0] s_word, s_rdata, s_rb;

   int n_chk = 0;
   int n_bad = 0;
   int n_main_ovr = 0;
   int n_slow_ovr = 0;
   int n_slow_done = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dac_refresh_seq #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .ENFORCE_BUDGET(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_chan(host_chan),
      .host_hi(host_hi), .host_data(host_data), .frm_start(frm_start),
      .frm_word(frm_word), .frm_done(frm_done), .frm_rdata(frm_rdata),
      .refresh_busy(refresh_busy), .burst_done(burst_done), .overrun(overrun),
      .sample_tick(sample_tick), .last_readback(last_readback));

   frame_engine_model #(.LAT(8)) eng (
      .clk(clk), .start(frm_start), .word(frm_word), .done(frm_done), .rdata(frm_rdata));

   dac_refresh_seq #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .ENFORCE_BUDGET(1'b0)) uut_ovr (
      .clk(clk), .rst_n(rst_n), .host_we(1'b0), .host_chan(2'd0),
      .host_hi(1'b0), .host_data(8'd0), .frm_start(s_start),
      .frm_word(s_word), .frm_done(s_done), .frm_rdata(s_rdata),
      .refresh_busy(s_busy), .burst_done(s_bdone), .overrun(s_ovr),
      .sample_tick(s_tick), .last_readback(s_rb));

   frame_engine_model #(.LAT(60)) eng_slow (
      .clk(clk), .start(s_start), .word(s_word), .done(s_done), .rdata(s_rdata));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int c, input logic [11:0] v);
      return {8'h00, 4'h3, 4'(c), v, 4'h0};
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   logic [11:0] mirror [4];

   task automatic host_wr(input int c, input bit hi, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_chan = 2'(c); host_hi = hi; host_data = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // R5: high part from data[7:0], low part from data[3:0], data[7:4] on a low write is junk
   task automatic write_val(input int c, input logic [11:0] v);
      host_wr(c, 1'b1, v[11:4]);
      host_wr(c, 1'b0, {4'hA ^ 4'(c), v[3:0]});
      mirror[c] = v;
   endtask

   // tick spacing and width monitor (R1) plus overrun counters (R9, R10)
   initial begin
      int cyc;
      int last;
      int seen;
      bit prev_tick;
      cyc = 0; last = -1; seen = 0; prev_tick = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (sample_tick) begin
               if (last >= 0 && seen < 10)
                  chk(cyc - last == DIV, "R1 tick spacing", 32'(cyc - last), 32'(DIV));
               if (prev_tick) chk(1'b0, "R1 tick width", 32'd2, 32'd1);
               last = cyc;
               seen++;
            end
            prev_tick = sample_tick;
            if (overrun) n_main_ovr++;
            if (s_ovr) n_slow_ovr++;
            if (s_bdone) n_slow_done++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", 32'd0, 32'd1);
         summary();
      end
   end

   initial begin
      logic [11:0] latched [4];
      bit          skip_writes;
      int          bad_order;
      for (int c = 0; c < 4; c++) mirror[c] = '0;
      skip_writes = 1'b0;
      repeat (5) @(negedge clk);
      // R11: reset state
      chk(!refresh_busy && !frm_start && !burst_done && !overrun && !sample_tick,
          "R11 reset controls", {27'd0, refresh_busy, frm_start, burst_done, overrun, sample_tick}, 32'd0);
      chk(last_readback == 32'd0, "R11 reset readback", last_readback, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!refresh_busy && !overrun, "R11 after release", {30'd0, refresh_busy, overrun}, 32'd0);

      for (int b = 0; b < NB; b++) begin
         if (!skip_writes) begin
            for (int c = 0; c < 4; c++) begin
               logic [11:0] v;
               if (b == 1)      v = 12'h000;
               else if (b == 2) v = 12'hFFF;
               else             v = 12'((b * 32'h9E3 + c * 32'h411 + 32'h07F) & 32'hFFF);
               write_val(c, v);
            end
         end
         skip_writes = 1'b0;
         for (int c = 0; c < 4; c++) latched[c] = mirror[c];
         if (b == 5) begin
            // R6: writes during a running burst go to the next burst
            do @(negedge clk); while (!refresh_busy);
            for (int c = 0; c < 4; c++) write_val(c, 12'h5A0 ^ 12'(c * 12'h111));
            skip_writes = 1'b1;
         end
         do @(negedge clk); while (!burst_done);
         chk(!refresh_busy, "R8 busy clear at done", {31'd0, refresh_busy}, 32'd0);
         chk(eng.n_log == 4 * (b + 1), "R2 frame count", 32'(eng.n_log), 32'(4 * (b + 1)));
         for (int c = 0; c < 4; c++)
            chk(eng.log_q[4 * b + c] == exp_word(c, latched[c]),
                (b == 6) ? "R6 next burst values" : (b == 5) ? "R6 snapshot values" : "R2 R3 R5 frame word",
                eng.log_q[4 * b + c], exp_word(c, latched[c]));
         chk(last_readback == exp_word(2, latched[2]), "R7 readback", last_readback, exp_word(2, latched[2]));
         @(negedge clk);
         chk(!burst_done, "R8 done pulse width", {31'd0, burst_done}, 32'd0);
      end

      // R4: single-cycle starts, none while a frame is outstanding
      chk(eng.n_overlap == 0, "R4 start while outstanding", 32'(eng.n_overlap), 32'd0);
      chk(eng.n_long == 0, "R4 start width", 32'(eng.n_long), 32'd0);
      chk(eng_slow.n_overlap == 0, "R4 slow start while outstanding", 32'(eng_slow.n_overlap), 32'd0);
      // R10: checked instance never overran
      chk(n_main_ovr == 0, "R10 no overrun in budget", 32'(n_main_ovr), 32'd0);
      // R9: slow instance overran but kept strict order without restart
      chk(n_slow_ovr > 0, "R9 overrun seen", 32'(n_slow_ovr), 32'd1);
      bad_order = 0;
      for (int i = 0; i < eng_slow.n_log && i < 256; i++)
         if (eng_slow.log_q[i][19:16] != 4'(i % 4)) bad_order++;
      chk(bad_order == 0, "R9 order kept under overrun", 32'(bad_order), 32'd0);
      chk(eng_slow.n_log >= 4 * n_slow_done && eng_slow.n_log <= 4 * n_slow_done + 4,
          "R9 no restart", 32'(eng_slow.n_log), 32'(4 * n_slow_done));
      chk(n_slow_ovr <= n_slow_done + 1, "R9 one drop per overlong burst", 32'(n_slow_ovr), 32'(n_slow_done + 1));
      finished = 1'b1;
      summary();
   end

endmodule